// File: doc/BRIEF.md
# Fetch Address Trap and Software Interrupt Unit

This unit sits between the instruction fetch stage of a small 8-bit processor and its interrupt logic. On every opcode fetch it looks at the fetch address, at a flag from the memory map that says whether any memory answers that address, and at the raw byte returned. When nothing answers, it replaces the byte with the software-interrupt opcode (0xFF). One address range is reserved for test code. Fetches there always pass the raw byte, even when the map flag is low.

A fetch whose address lies in the special-function-register space or in the data RAM space is an illegal code fetch. For such a fetch the unit issues a one-cycle trap reset. When the opcode handed to the core equals the software-interrupt opcode, the unit raises a software interrupt request, which is the highest-priority request in the system. The request stays raised until the interrupt controller acknowledges it. If a non-maskable interrupt is already in service, no request is raised and the core executes the byte as a no-operation. The core and the vectoring logic are outside this unit.

Top module: `fetch_trap_swi`

## Requirements
- R1: During an opcode fetch, when `map_hit_i` is 0 and the address lies outside the test range, `opcode_o` equals 0xFF in the same cycle; when `map_hit_i` is 1, `opcode_o` equals `fetch_data_i`.
- R2: For addresses 0x3F80 to 0x3FFF, `opcode_o` equals `fetch_data_i` whatever the value of `map_hit_i`.
- R3: A fetch (`fetch_stb_i`=1) outside both trap ranges whose delivered opcode is 0xFF, with `nmi_busy_i`=0, sets `swi_req_o` at the next rising clock edge.
- R4: While `nmi_busy_i` is 1, a fetch of 0xFF leaves `swi_req_o` low, and `opcode_o` still shows 0xFF so that the core runs it as a no-operation.
- R5: `swi_req_o` stays 1 until a cycle with `swi_ack_i`=1 and clears at that edge. If a new qualifying fetch happens in the acknowledge cycle, `swi_req_o` stays 1.
- R6: A fetch from 0x0000 to 0x003F (register space) drives `trap_rst_o` to 1 in the cycle after the fetch. The edges 0x0000 and 0x003F are included.
- R7: A fetch from 0x0040 to 0x083F (RAM space) drives `trap_rst_o` to 1 in the cycle after the fetch. 0x0840 does not trap.
- R8: `trap_rst_o` is high for exactly one cycle, even when the fetch strobe stays on a trapping address for two cycles.
- R9: With `fetch_stb_i`=0 (a data access), addresses in either trap range raise neither `trap_rst_o` nor `swi_req_o`.
- R10: A fetch in a trap range whose byte is 0xFF raises the trap and does not raise `swi_req_o`.
- R11: A synchronous reset (`rst_i`=1 at a rising edge) clears `trap_rst_o` and `swi_req_o`, including a request that is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| fetch_stb_i | input | 1 | Opcode fetch strobe for this cycle |
| fetch_addr_i | input | 16 | Fetch address |
| map_hit_i | input | 1 | Memory answers the fetch address |
| fetch_data_i | input | 8 | Raw byte from memory |
| nmi_busy_i | input | 1 | A non-maskable interrupt is in service |
| swi_ack_i | input | 1 | Interrupt controller acknowledges the software request |
| opcode_o | output | 8 | Opcode handed to the core |
| trap_rst_o | output | 1 | Address-trap reset pulse |
| swi_req_o | output | 1 | Software interrupt request |

## Verification
`opcode_o` is combinational, so the bench reads it one time step after it drives the fetch inputs on the falling clock edge, in the same cycle. `trap_rst_o` and `swi_req_o` each pass through one register. The bench samples them just after the next rising edge, which is the first point where they can have changed. For the single-cycle pulse and for the acknowledge rules it reads them again one edge later. Every stimulus is driven at a falling edge, so sampling never coincides with the edge that updates the registers.

// File: rtl/fat_pkg.sv
package fat_pkg;
   // hits of the fetch address in the decoded ranges
   typedef struct packed {
      logic sfr;
      logic ram;
      logic tst;
   } fat_hit_t;

   localparam int unsigned FAT_DATA_W  = 8;
   localparam logic [FAT_DATA_W-1:0] FAT_SWI_OPC = 8'hFF;
endpackage

// File: rtl/fat_win_hit.sv
module fat_win_hit #(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] LO = '0,
   parameter logic [ADDR_W-1:0] HI = '1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   if (HI < LO) begin : g_bad
      $error("fat_win_hit: HI below LO");
   end

   if (LO == '0) begin : g_from_zero
      assign hit_o = (addr_i <= HI);
   end else begin : g_range
      assign hit_o = (addr_i >= LO) && (addr_i <= HI);
   end
endmodule

// File: rtl/fat_opc_sel.sv
module fat_opc_sel #(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] SWI_OPC = '1
) (
   input  logic              answered_i,
   input  logic [DATA_W-1:0] raw_i,
   output logic [DATA_W-1:0] opc_o
);
   always_comb begin
      opc_o = answered_i ? raw_i : SWI_OPC;
   end
endmodule

// File: rtl/fat_swi_ctl.sv
module fat_swi_ctl (
   input  logic clk_i,
   input  logic rst_i,
   input  logic set_i,
   input  logic ack_i,
   output logic req_o
);
   logic req_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         req_q <= 1'b0;
      end else begin
         req_q <= set_i | (req_q & ~ack_i);
      end
   end

   assign req_o = req_q;
endmodule

// File: rtl/fetch_trap_swi.sv
module fetch_trap_swi
   import fat_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = FAT_DATA_W,
   parameter logic [ADDR_W-1:0] SFR_LO  = 16'h0000,
   parameter logic [ADDR_W-1:0] SFR_HI  = 16'h003F,
   parameter logic [ADDR_W-1:0] RAM_LO  = 16'h0040,
   parameter logic [ADDR_W-1:0] RAM_HI  = 16'h083F,
   parameter logic [ADDR_W-1:0] TEST_LO = 16'h3F80,
   parameter logic [ADDR_W-1:0] TEST_HI = 16'h3FFF,
   parameter bit TEST_PASS = 1'b1,
   parameter logic [DATA_W-1:0] SWI_OPC = FAT_SWI_OPC
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              fetch_stb_i,
   input  logic [ADDR_W-1:0] fetch_addr_i,
   input  logic              map_hit_i,
   input  logic [DATA_W-1:0] fetch_data_i,
   input  logic              nmi_busy_i,
   input  logic              swi_ack_i,
   output logic [DATA_W-1:0] opcode_o,
   output logic              trap_rst_o,
   output logic              swi_req_o
);
   localparam int unsigned N_TRAP_WIN = 2;

   if (ADDR_W < 8) begin : g_bad_aw
      $error("fetch_trap_swi: ADDR_W too small");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("fetch_trap_swi: DATA_W must be positive");
   end
   if (TEST_PASS && (TEST_LO <= RAM_HI) && (TEST_HI >= SFR_LO)) begin : g_bad_ovl
      $error("fetch_trap_swi: test range overlaps trap ranges");
   end

   fat_hit_t            hit;
   logic [N_TRAP_WIN-1:0] trap_vec;
   logic                trap_hit;
   logic                answered;
   logic                swi_set;
   logic                trap_q;

   fat_win_hit #(.ADDR_W(ADDR_W), .LO(SFR_LO), .HI(SFR_HI)) u_sfr_win (
      .addr_i (fetch_addr_i),
      .hit_o  (hit.sfr)
   );

   fat_win_hit #(.ADDR_W(ADDR_W), .LO(RAM_LO), .HI(RAM_HI)) u_ram_win (
      .addr_i (fetch_addr_i),
      .hit_o  (hit.ram)
   );

   if (TEST_PASS) begin : g_test_win
      fat_win_hit #(.ADDR_W(ADDR_W), .LO(TEST_LO), .HI(TEST_HI)) u_tst_win (
         .addr_i (fetch_addr_i),
         .hit_o  (hit.tst)
      );
   end else begin : g_no_test_win
      assign hit.tst = 1'b0;
   end

   assign trap_vec = {hit.ram, hit.sfr};
   assign trap_hit = |trap_vec;
   assign answered = map_hit_i | hit.tst;

   fat_opc_sel #(.DATA_W(DATA_W), .SWI_OPC(SWI_OPC)) u_opc (
      .answered_i (answered),
      .raw_i      (fetch_data_i),
      .opc_o      (opcode_o)
   );

   assign swi_set = fetch_stb_i & ~trap_hit & ~nmi_busy_i & (opcode_o == SWI_OPC);

   fat_swi_ctl u_swi (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .set_i  (swi_set),
      .ack_i  (swi_ack_i),
      .req_o  (swi_req_o)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         trap_q <= 1'b0;
      end else begin
         trap_q <= fetch_stb_i & trap_hit & ~trap_q;
      end
   end

   assign trap_rst_o = trap_q;
endmodule

// File: rtl/fetch_trap_swi_chk.sv
module fetch_trap_swi_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] SFR_LO  = 16'h0000,
   parameter logic [ADDR_W-1:0] SFR_HI  = 16'h003F,
   parameter logic [ADDR_W-1:0] RAM_LO  = 16'h0040,
   parameter logic [ADDR_W-1:0] RAM_HI  = 16'h083F,
   parameter logic [ADDR_W-1:0] TEST_LO = 16'h3F80,
   parameter logic [ADDR_W-1:0] TEST_HI = 16'h3FFF,
   parameter bit TEST_PASS = 1'b1,
   parameter logic [DATA_W-1:0] SWI_OPC = 8'hFF
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              fetch_stb_i,
   input logic [ADDR_W-1:0] fetch_addr_i,
   input logic              map_hit_i,
   input logic              nmi_busy_i,
   input logic              swi_ack_i,
   input logic [DATA_W-1:0] opcode_o,
   input logic              trap_rst_o,
   input logic              swi_req_o
);
   function automatic logic in_rng(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] lo,
                                   input logic [ADDR_W-1:0] hi);
      logic [ADDR_W-1:0] off;
      logic [ADDR_W-1:0] span;
      off  = a - lo;
      span = hi - lo;
      return off <= span;
   endfunction

   logic bad_win;
   logic tst_win;
   assign bad_win = in_rng(fetch_addr_i, SFR_LO, SFR_HI) | in_rng(fetch_addr_i, RAM_LO, RAM_HI);
   assign tst_win = TEST_PASS & in_rng(fetch_addr_i, TEST_LO, TEST_HI);

   // R1
   unmapped_forced_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!map_hit_i && !tst_win) |-> (opcode_o == SWI_OPC));

   // R6 R7
   trap_follows_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (fetch_stb_i && bad_win && !trap_rst_o) |=> trap_rst_o);

   // R8
   trap_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      trap_rst_o |=> !trap_rst_o);

   // R9
   trap_needs_fetch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !fetch_stb_i |=> !trap_rst_o);

   // R5
   swi_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (swi_req_o && !swi_ack_i) |=> swi_req_o);

   // R4
   swi_nmi_block_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (nmi_busy_i && !swi_req_o) |=> !swi_req_o);

   // R10
   swi_no_trap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (bad_win && !swi_req_o) |=> !swi_req_o);

   // R11
   reset_clear_chk: assert property (@(posedge clk_i)
      rst_i |=> (!trap_rst_o && !swi_req_o));
endmodule

bind fetch_trap_swi fetch_trap_swi_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .SFR_LO(SFR_LO), .SFR_HI(SFR_HI), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI),
   .TEST_LO(TEST_LO), .TEST_HI(TEST_HI), .TEST_PASS(TEST_PASS), .SWI_OPC(SWI_OPC)
) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .fetch_stb_i(fetch_stb_i),
   .fetch_addr_i(fetch_addr_i), .map_hit_i(map_hit_i),
   .nmi_busy_i(nmi_busy_i), .swi_ack_i(swi_ack_i), .opcode_o(opcode_o),
   .trap_rst_o(trap_rst_o), .swi_req_o(swi_req_o)
);

// File: tb/fetch_trap_swi_bench.sv
module fetch_trap_swi_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic        fetch_stb;
   logic [15:0] fetch_addr;
   logic        map_hit;
   logic [7:0]  fetch_data;
   logic        nmi_busy;
   logic        swi_ack;
   logic [7:0]  opcode;
   logic        trap_rst;
   logic        swi_req;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   fetch_trap_swi u_fetch_trap_swi (
      .clk_i(clk), .rst_i(rst), .fetch_stb_i(fetch_stb), .fetch_addr_i(fetch_addr),
      .map_hit_i(map_hit), .fetch_data_i(fetch_data), .nmi_busy_i(nmi_busy),
      .swi_ack_i(swi_ack), .opcode_o(opcode), .trap_rst_o(trap_rst), .swi_req_o(swi_req)
   );

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      fetch_stb = 1'b0; swi_ack = 1'b0; nmi_busy = 1'b0;
      map_hit = 1'b1; fetch_data = 8'h00; fetch_addr = 16'h1000;
   endtask

   // drive one fetch at a falling edge; returns after the next rising edge + 1
   task automatic do_fetch(input logic [15:0] a, input logic [7:0] d,
                           input logic mh, input logic nmi, input logic stb,
                           output logic [7:0] opc_seen);
      @(negedge clk);
      fetch_addr = a; fetch_data = d; map_hit = mh; nmi_busy = nmi; fetch_stb = stb;
      #1 opc_seen = opcode;
      @(posedge clk); #1;
   endtask

   task automatic clear_swi();
      @(negedge clk);
      fetch_stb = 1'b0; swi_ack = 1'b1;
      @(posedge clk); #1;
      idle();
   endtask

   task automatic t_reset();
      rst = 1'b1;
      idle();
      repeat (2) @(posedge clk);
      #1;
      chk("R11", "trap after reset", {15'd0, trap_rst}, 16'd0);
      chk("R11", "swi after reset", {15'd0, swi_req}, 16'd0);
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic t_unmapped();
      logic [7:0] o;
      do_fetch(16'h2000, 8'h3C, 1'b1, 1'b0, 1'b1, o);
      chk("R1", "mapped opcode", {8'd0, o}, 16'h003C);
      chk("R3", "no swi for plain byte", {15'd0, swi_req}, 16'd0);
      do_fetch(16'h5000, 8'h3C, 1'b0, 1'b0, 1'b1, o);
      chk("R1", "unmapped opcode", {8'd0, o}, 16'h00FF);
      chk("R3", "swi from unmapped", {15'd0, swi_req}, 16'd1);
      idle();
      clear_swi();
   endtask

   task automatic t_test_area();
      logic [7:0] o;
      do_fetch(16'h3F80, 8'h5A, 1'b0, 1'b0, 1'b1, o);
      chk("R2", "test low edge", {8'd0, o}, 16'h005A);
      chk("R2", "no swi in test", {15'd0, swi_req}, 16'd0);
      do_fetch(16'h3FFF, 8'hA5, 1'b0, 1'b0, 1'b1, o);
      chk("R2", "test high edge", {8'd0, o}, 16'h00A5);
      do_fetch(16'h3F7F, 8'hA5, 1'b0, 1'b0, 1'b1, o);
      chk("R1", "below test forced", {8'd0, o}, 16'h00FF);
      idle();
      clear_swi();
   endtask

   task automatic t_swi_ack();
      logic [7:0] o;
      do_fetch(16'h2100, 8'hFF, 1'b1, 1'b0, 1'b1, o);
      chk("R3", "swi set next edge", {15'd0, swi_req}, 16'd1);
      idle();
      repeat (3) @(posedge clk);
      #1 chk("R5", "swi held without ack", {15'd0, swi_req}, 16'd1);
      // ack together with a new qualifying fetch keeps it set
      @(negedge clk);
      swi_ack = 1'b1; fetch_stb = 1'b1; fetch_addr = 16'h2200; fetch_data = 8'hFF; map_hit = 1'b1;
      @(posedge clk); #1;
      chk("R5", "ack with new swi", {15'd0, swi_req}, 16'd1);
      clear_swi();
      chk("R5", "cleared by ack", {15'd0, swi_req}, 16'd0);
   endtask

   task automatic t_nmi();
      logic [7:0] o;
      do_fetch(16'h2300, 8'hFF, 1'b1, 1'b1, 1'b1, o);
      chk("R4", "opcode under nmi", {8'd0, o}, 16'h00FF);
      chk("R4", "no swi under nmi", {15'd0, swi_req}, 16'd0);
      do_fetch(16'h6000, 8'h00, 1'b0, 1'b1, 1'b1, o);
      chk("R4", "no swi unmapped nmi", {15'd0, swi_req}, 16'd0);
      idle();
   endtask

   task automatic t_trap_edges();
      logic [7:0] o;
      logic [15:0] addrs [5] = '{16'h0000, 16'h003F, 16'h0040, 16'h083F, 16'h0840};
      logic        exp   [5] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
      string       tag   [5] = '{"R6", "R6", "R7", "R7", "R7"};
      for (int i = 0; i < 5; i++) begin
         do_fetch(addrs[i], 8'h12, 1'b1, 1'b0, 1'b1, o);
         chk(tag[i], $sformatf("trap at %h", addrs[i]), {15'd0, trap_rst}, {15'd0, exp[i]});
         idle();
         @(posedge clk); #1;
         chk("R8", "trap gone", {15'd0, trap_rst}, 16'd0);
      end
   endtask

   task automatic t_trap_hold();
      logic [7:0] o;
      do_fetch(16'h0100, 8'h12, 1'b1, 1'b0, 1'b1, o);
      chk("R8", "trap first cycle", {15'd0, trap_rst}, 16'd1);
      @(posedge clk); #1;
      chk("R8", "trap second cycle", {15'd0, trap_rst}, 16'd0);
      idle();
      @(posedge clk); #1;
   endtask

   task automatic t_data_access();
      logic [7:0] o;
      do_fetch(16'h0010, 8'hFF, 1'b1, 1'b0, 1'b0, o);
      chk("R9", "no trap on sfr read", {15'd0, trap_rst}, 16'd0);
      chk("R9", "no swi on sfr read", {15'd0, swi_req}, 16'd0);
      do_fetch(16'h0400, 8'hFF, 1'b1, 1'b0, 1'b0, o);
      chk("R9", "no trap on ram read", {15'd0, trap_rst}, 16'd0);
      idle();
   endtask

   task automatic t_trap_ff();
      logic [7:0] o;
      do_fetch(16'h0500, 8'hFF, 1'b1, 1'b0, 1'b1, o);
      chk("R10", "trap on ff in ram", {15'd0, trap_rst}, 16'd1);
      chk("R10", "no swi on trap", {15'd0, swi_req}, 16'd0);
      idle();
      @(posedge clk); #1;
   endtask

   task automatic t_reset_pending();
      logic [7:0] o;
      do_fetch(16'h2400, 8'hFF, 1'b1, 1'b0, 1'b1, o);
      chk("R3", "swi before reset", {15'd0, swi_req}, 16'd1);
      @(negedge clk);
      fetch_stb = 1'b0; rst = 1'b1;
      @(posedge clk); #1;
      chk("R11", "pending swi reset", {15'd0, swi_req}, 16'd0);
      @(negedge clk); rst = 1'b0;
      idle();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_unmapped();
      t_test_area();
      t_swi_ack();
      t_nmi();
      t_trap_edges();
      t_trap_hold();
      t_data_access();
      t_trap_ff();
      t_reset_pending();
      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule